// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

This block resolves a logical address into a physical address by walking a tree of translation tables held in memory. A request supplies the logical address, the base of the top-level table and the entry size of that table. The walker then fetches one descriptor per level through a single-outstanding memory read port. It decodes the type field of each descriptor and either descends to the next table, stops on a page, or stops on an invalid entry. Its product is one translation-cache entry: a physical address, a write-protect flag and an error flag. A translation cache or retry controller that sits beside the walker consumes this entry.

The logical address is split into a fixed number of equal-width table indices, taken from the most significant end, followed by a page offset. A table holds either one-word (short) or two-word (long) entries. The pointer that leads to a table sets which size that table uses, and a root flag sets it for the top table. A pointer found where the last level expects a page is an indirect reference. The walker fetches the one descriptor it names, and that descriptor has to be a page or invalid. Because write protection is gathered from every descriptor on the path, two tasks can reach the same shared lower table with different rights.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `rd_req` are low until a request is accepted.
- R2: A descriptor for level k is read at table base + index_k×4 for a short table or + index_k×8 for a long table. index_k is the k-th IDX_W-bit field of the logical address, counted from the most significant end. The second word of a long descriptor is read at +4.
- R3: Descriptor word 0 carries the type in bits [1:0] (0 invalid, 1 page, 2 pointer to a table of short entries, 3 pointer to a table of long entries) and a write-protect flag in bit 2. A short descriptor's address is its bits [31:3] with three zero bits appended. A long descriptor's address is its whole second word.
- R4: A page reached at the last level yields a physical address made of the page address with its low PAGE_W bits replaced by the logical page offset, with `res_err` low.
- R5: A page reached at an upper level ends the walk early. The unused lower index bits join the offset, and the page address bits below that larger page size are ignored.
- R6: `res_wp` is the OR of the write-protect flags of every pointer and page descriptor on the path, so one shared table can be write-protected for one path and writable through another.
- R7: An invalid descriptor ends the walk at once and causes no further reads. The result has `res_err` high and `res_paddr` zero. No bit of the invalid descriptor other than its type affects the result, so `res_wp` reflects only the descriptors before it.
- R8: A pointer at the last level is followed as an indirect reference. One descriptor is fetched at its address with no index added, sized by the pointer's type. If that descriptor is a page, it yields a last-level page result with the protection of the indirect and target ORed in.
- R9: An indirect target whose type is a short or long table pointer, or invalid, produces an error entry.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle `done` pulses for one cycle with the result. A `start` while busy is ignored.
- R11: `rd_req` stays high with a stable `rd_addr` until `rd_valid` is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a walk (accepted when idle) |
| laddr | input | LA_W | Logical address to translate |
| root_base | input | 32 | Base address of the top-level table |
| root_long | input | 1 | Top-level table holds two-word entries |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse, result valid |
| res_paddr | output | 32 | Translated physical address, zero on error |
| res_wp | output | 1 | Accumulated write protection |
| res_err | output | 1 | Error entry (invalid or misplaced descriptor) |
| rd_req | output | 1 | Memory read request, held until served |
| rd_addr | output | 32 | Memory read byte address |
| rd_data | input | 32 | Memory read data |
| rd_valid | input | 1 | Read data valid, one cycle |

## Verification
The hardest case to reach from the ports is an indirect reference whose target is itself a table pointer. It needs a full path of valid pointers down to the last level, then a pointer there, then a long-format target whose type field names another table. The bench builds a sparse memory image in which one last-level table holds indirect references to a valid page, to an invalid word and to such a pointer. It also holds two root entries that converge on one shared table with different protection flags. Each result is compared with the number of reads it took, so an early or late stop shows up even when the result fields happen to match.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DESC_W = 32;

  typedef enum logic [1:0] {
    DT_INVALID   = 2'd0,
    DT_PAGE      = 2'd1,
    DT_SHORT_TBL = 2'd2,
    DT_LONG_TBL  = 2'd3
  } dtype_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_EVAL
  } wstate_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int LA_W    = 32,
  parameter int NUM_LVL = 3,
  parameter int IDX_W   = 8,
  parameter int LVL_W   = 2
) (
  input  logic [LA_W-1:0]            laddr,
  input  logic [ptw_pkg::DESC_W-1:0] base,
  input  logic [LVL_W-1:0]           lvl,
  input  logic                       long_tbl,
  input  logic                       indir,
  input  logic                       hi_word,
  output logic [ptw_pkg::DESC_W-1:0] addr
);
  localparam int AW = ptw_pkg::DESC_W;

  logic [IDX_W-1:0] idx_sel [NUM_LVL];
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    offs;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_idx
    assign idx_sel[g] = laddr[LA_W-1-g*IDX_W -: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (lvl == LVL_W'(i)) idx = idx_sel[i];
    end
    if (indir) idx = '0;
  end

  always_comb begin
    offs = long_tbl ? (AW'(idx) << 3) : (AW'(idx) << 2);
    addr = base + offs + (hi_word ? AW'(4) : AW'(0));
  end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode (
  input  logic [ptw_pkg::DESC_W-1:0] w_lo,
  input  logic [ptw_pkg::DESC_W-1:0] w_hi,
  input  logic                       is_long,
  output ptw_pkg::dtype_e            dtype,
  output logic                       wp,
  output logic [ptw_pkg::DESC_W-1:0] next_addr
);
  always_comb begin
    dtype     = ptw_pkg::dtype_e'(w_lo[1:0]);
    wp        = w_lo[2];
    next_addr = is_long ? w_hi : {w_lo[ptw_pkg::DESC_W-1:3], 3'b000};
  end
endmodule

// File: rtl/ptw_result_form.sv
module ptw_result_form #(
  parameter int LA_W    = 32,
  parameter int NUM_LVL = 3,
  parameter int IDX_W   = 8,
  parameter int LVL_W   = 2
) (
  input  logic [ptw_pkg::DESC_W-1:0] page_addr,
  input  logic [LA_W-1:0]            laddr,
  input  logic [LVL_W-1:0]           lvl,
  input  logic                       indir,
  output logic [ptw_pkg::DESC_W-1:0] paddr
);
  localparam int PA_W   = ptw_pkg::DESC_W;
  localparam int PAGE_W = LA_W - NUM_LVL*IDX_W;

  logic [PA_W-1:0] mask;
  logic [PA_W-1:0] la_ext;

  always_comb begin
    mask = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (lvl == LVL_W'(i))
        mask = PA_W'((64'd1 << (PAGE_W + IDX_W*(NUM_LVL-1-i))) - 64'd1);
    end
    if (indir) mask = PA_W'((64'd1 << PAGE_W) - 64'd1);
  end

  always_comb begin
    la_ext = PA_W'(laddr);
    paddr  = (page_addr & ~mask) | (la_ext & mask);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int LA_W    = 32,
  parameter int NUM_LVL = 3,
  parameter int IDX_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [LA_W-1:0]            laddr,
  input  logic [ptw_pkg::DESC_W-1:0] root_base,
  input  logic                       root_long,
  output logic                       busy,
  output logic                       done,
  output logic [ptw_pkg::DESC_W-1:0] res_paddr,
  output logic                       res_wp,
  output logic                       res_err,
  output logic                       rd_req,
  output logic [ptw_pkg::DESC_W-1:0] rd_addr,
  input  logic [ptw_pkg::DESC_W-1:0] rd_data,
  input  logic                       rd_valid
);
  import ptw_pkg::*;

  localparam int LVL_W = $clog2(NUM_LVL + 1);
  localparam int AW    = DESC_W;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_LVL - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // walk state
  wstate_e          state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [AW-1:0]    base_q, base_d;
  logic             long_q, long_d;
  logic             indir_q, indir_d;
  logic             wp_q, wp_d;
  logic [LA_W-1:0]  la_q, la_d;
  logic [AW-1:0]    wlo_q, whi_q;
  logic             wlo_en, whi_en;
  logic             fin, fin_err, fin_wp;
  logic             done_q;
  logic [AW-1:0]    pa_q;
  logic             rwp_q, rerr_q;

  dtype_e        dec_type;
  logic          dec_wp;
  logic [AW-1:0] dec_addr;
  logic [AW-1:0] page_pa;

  ptw_addr_gen #(
    .LA_W(LA_W), .NUM_LVL(NUM_LVL), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) u_addr (
    .laddr    (la_q),
    .base     (base_q),
    .lvl      (lvl_q),
    .long_tbl (long_q),
    .indir    (indir_q),
    .hi_word  (state_q == ST_FETCH_HI),
    .addr     (rd_addr)
  );

  ptw_desc_decode u_dec (
    .w_lo      (wlo_q),
    .w_hi      (whi_q),
    .is_long   (long_q),
    .dtype     (dec_type),
    .wp        (dec_wp),
    .next_addr (dec_addr)
  );

  ptw_result_form #(
    .LA_W(LA_W), .NUM_LVL(NUM_LVL), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) u_res (
    .page_addr (dec_addr),
    .laddr     (la_q),
    .lvl       (lvl_q),
    .indir     (indir_q),
    .paddr     (page_pa)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    long_d  = long_q;
    indir_d = indir_q;
    wp_d    = wp_q;
    la_d    = la_q;
    wlo_en  = 1'b0;
    whi_en  = 1'b0;
    fin     = 1'b0;
    fin_err = 1'b0;
    fin_wp  = wp_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          la_d    = laddr;
          base_d  = root_base;
          long_d  = root_long;
          lvl_d   = '0;
          indir_d = 1'b0;
          wp_d    = 1'b0;
          state_d = ST_FETCH_LO;
        end
      end
      ST_FETCH_LO: begin
        if (rd_valid) begin
          wlo_en  = 1'b1;
          state_d = long_q ? ST_FETCH_HI : ST_EVAL;
        end
      end
      ST_FETCH_HI: begin
        if (rd_valid) begin
          whi_en  = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        state_d = ST_FETCH_LO;
        unique case (dec_type)
          DT_INVALID: begin
            fin     = 1'b1;
            fin_err = 1'b1;
          end
          DT_PAGE: begin
            fin    = 1'b1;
            fin_wp = wp_q | dec_wp;
          end
          default: begin
            if (indir_q) begin
              fin     = 1'b1;
              fin_err = 1'b1;
            end else begin
              wp_d   = wp_q | dec_wp;
              base_d = dec_addr;
              long_d = (dec_type == DT_LONG_TBL);
              if (lvl_q == LAST_LVL) indir_d = 1'b1;
              else                   lvl_d   = lvl_q + LVL_W'(1);
            end
          end
        endcase
        if (fin) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      long_q  <= 1'b0;
      indir_q <= 1'b0;
      wp_q    <= 1'b0;
      la_q    <= '0;
      wlo_q   <= '0;
      whi_q   <= '0;
      done_q  <= 1'b0;
      pa_q    <= '0;
      rwp_q   <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      base_q  <= base_d;
      long_q  <= long_d;
      indir_q <= indir_d;
      wp_q    <= wp_d;
      la_q    <= la_d;
      done_q  <= fin;
      if (wlo_en) wlo_q <= rd_data;
      if (whi_en) whi_q <= rd_data;
      if (fin) begin
        pa_q   <= fin_err ? '0 : page_pa;
        rwp_q  <= fin_wp;
        rerr_q <= fin_err;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign rd_req    = (state_q == ST_FETCH_LO) || (state_q == ST_FETCH_HI);
  assign done      = done_q;
  assign res_paddr = pa_q;
  assign res_wp    = rwp_q;
  assign res_err   = rerr_q;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  // R10
  req_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_req |-> busy);

  // R10
  walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> $past(start));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && res_err) |-> (res_paddr == '0));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] laddr;
  logic [31:0] root_base;
  logic        root_long;
  logic        busy, done, res_wp, res_err, rd_req, rd_valid;
  logic [31:0] res_paddr, rd_addr, rd_data;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .laddr(laddr),
    .root_base(root_base), .root_long(root_long), .busy(busy), .done(done),
    .res_paddr(res_paddr), .res_wp(res_wp), .res_err(res_err),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct {
    logic [31:0] pa;
    logic        wp;
    logic        err;
    int          nrd;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mem [int unsigned];
  int          n_chk = 0;
  int          n_bad = 0;
  int          n_rd  = 0;
  int          lat   = 0;
  bit          finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_valid = 1'b0;
      lat      = 0;
    end else begin
      if (rd_valid) rd_valid = 1'b0;
      else if (rd_req) begin
        if (lat == 2) begin
          lat = 0;
          rd_valid = 1'b1;
          n_rd++;
          if (mem.exists(rd_addr)) rd_data = mem[rd_addr];
          else begin
            rd_data = 32'h0;
            chk("R2 read of unmapped address", rd_addr, 32'hFFFF_FFFF);
          end
        end else lat++;
      end
      if (done) begin
        if (q.size() == 0) chk("R10 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " paddr"}, res_paddr, e.pa);
          chk({e.tag, " wp"}, {31'd0, res_wp}, {31'd0, e.wp});
          chk({e.tag, " err"}, {31'd0, res_err}, {31'd0, e.err});
          chk({e.tag, " reads R2"}, n_rd, e.nrd);
        end
        n_rd = 0;
      end
    end
  end

  task automatic walk(input logic [31:0] la, input logic [31:0] rb, input logic rl,
                      input logic [31:0] pa, input logic wp, input logic err,
                      input int nrd, input string tag);
    exp_t e;
    while (busy || done) @(negedge clk);
    e.pa = pa; e.wp = wp; e.err = err; e.nrd = nrd; e.tag = tag;
    q.push_back(e);
    laddr = la; root_base = rb; root_long = rl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; laddr = '0; root_base = '0; root_long = 1'b0;
    rd_valid = 1'b0; rd_data = '0;
    // level 0 short table at 0x1000
    mem[32'h1004] = 32'h0000_2002; // short tbl 0x2000, wp0
    mem[32'h1008] = 32'h5500_0005; // page at level 0, wp1
    mem[32'h100C] = 32'h0000_4002; // short tbl 0x4000, wp0
    mem[32'h1010] = 32'h0000_2006; // same 0x2000, wp1 (shared)
    // level 1 short table at 0x2000
    mem[32'h2008] = 32'h0000_3007; // long tbl 0x3000, wp1
    mem[32'h200C] = 32'h0000_3003; // long tbl 0x3000, wp0
    mem[32'h2014] = 32'h1234_F001; // early page, low bits ignored
    mem[32'h2018] = 32'h0000_5002; // short tbl 0x5000
    // level 2 long table at 0x3000
    mem[32'h3000] = 32'h0000_0001; mem[32'h3004] = 32'h00CC_0000;
    mem[32'h3018] = 32'h0000_0001; mem[32'h301C] = 32'h00AB_CD00;
    // invalid with software bits
    mem[32'h4010] = 32'hDEAD_BEE4;
    // level 2 short table at 0x5000 holding indirect references
    mem[32'h5004] = 32'h0000_6102; // -> invalid target
    mem[32'h5008] = 32'h0000_6006; // -> page target, wp1
    mem[32'h5014] = 32'h0000_7003; // -> long target that is a pointer
    mem[32'h6000] = 32'h0077_7701;
    mem[32'h6100] = 32'h0000_0000;
    mem[32'h7000] = 32'h0000_0002; mem[32'h7004] = 32'h0000_8000;
    // long root at 0x9000
    mem[32'h9000] = 32'h0000_0005; mem[32'h9004] = 32'hAB00_0000;

    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 rd_req in reset", {31'd0, rd_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 rd_req after reset", {31'd0, rd_req}, 32'd0);

    walk(32'h0102_0345, 32'h1000, 1'b0, 32'h00AB_CD45, 1'b1, 1'b0, 4, "R4 R6 R3 full walk");
    walk(32'h0105_7799, 32'h1000, 1'b0, 32'h1234_7799, 1'b0, 1'b0, 2, "R5 level1 page");
    walk(32'h0211_2233, 32'h1000, 1'b0, 32'h5511_2233, 1'b1, 1'b0, 1, "R5 R6 level0 page");
    walk(32'h0304_0010, 32'h1000, 1'b0, 32'h0,         1'b0, 1'b1, 2, "R7 invalid");
    walk(32'h0106_02AA, 32'h1000, 1'b0, 32'h0077_77AA, 1'b1, 1'b0, 4, "R8 indirect page");
    walk(32'h0106_0500, 32'h1000, 1'b0, 32'h0,         1'b0, 1'b1, 5, "R9 indirect to pointer");
    // R10: start while busy must be ignored
    repeat (3) @(negedge clk);
    chk("R10 busy during walk", {31'd0, busy}, 32'd1);
    laddr = 32'h0211_2233; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    walk(32'h0106_0100, 32'h1000, 1'b0, 32'h0,         1'b0, 1'b1, 4, "R9 indirect to invalid");
    walk(32'h0000_0007, 32'h9000, 1'b1, 32'hAB00_0007, 1'b1, 1'b0, 2, "R2 R3 long root");
    walk(32'h0403_0055, 32'h1000, 1'b0, 32'h00CC_0055, 1'b1, 1'b0, 4, "R6 shared wp path");
    walk(32'h0103_0055, 32'h1000, 1'b0, 32'h00CC_0055, 1'b0, 1'b0, 4, "R6 shared rw path");

    for (int i = 0; i < 200 && (q.size() != 0 || busy); i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R10 results outstanding", q.size(), 32'd0);
    chk("R10 idle at end", {31'd0, busy}, 32'd0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule